// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Datapath

This block is the arithmetic core of a 16-bit signal-processing pipeline. Each cycle it can accept one decoded operation together with two 16-bit operands. It forms a 17-by-17 product, which is either signed or unsigned and either integer or fractional. The product can replace, be added into, or be subtracted from one of two 40-bit accumulators. Each accumulator holds 8 guard bits above a 16-bit high word and a 16-bit low word.

The block also runs operations that work on the accumulators alone: add the two, subtract one from the other, negate, and clear. A store path reduces an accumulator to a 16-bit word for writing to data memory. It rounds either conventionally or to nearest-even, and it can clamp the word to the 16-bit range.

A small configuration register sets the product form, the rounding style and the saturation behaviour. Saturation is enabled separately for each accumulator and for the store path. It clamps either to the 32-bit signed range (normal) or to the full 40-bit range (extended). Level overflow flags and sticky clamp flags are exported for each accumulator.

Top module: `dsp_mac_engine`

## Requirements
- R1: While rst_n is low, both accumulators, the configuration register, store_valid, store_data, the overflow flags and the sticky flags are all zero.
- R2: A cycle with cfg_we high loads cfg_wdata into the configuration register. The bit positions are: bit0 fractional, bit1 unsigned, bit2 convergent rounding, bit3 saturate accumulator A, bit4 saturate accumulator B, bit5 saturate stores, bit6 extended saturation. An operation issued in a later cycle uses the new setting.
- R3: Operation code 1 (multiply) loads the product into the selected accumulator (acc_sel 0 selects A, 1 selects B). Operands are zero-extended when the unsigned bit is set and sign-extended otherwise. In fractional mode the product is doubled. The result is sign-extended to 40 bits.
- R4: Code 2 adds the product to the selected accumulator and code 3 subtracts it. The accumulator not selected keeps its value. Codes 9 to 15, and any cycle with op_valid low, change nothing.
- R5: Code 5 writes A+B into the selected accumulator. Code 6 writes the selected accumulator minus the other one. Code 7 writes the negation of the selected accumulator.
- R6: With normal saturation (bit6 clear), a result written to an accumulator whose saturation bit is set is clamped to the range -2^31 to 2^31-1.
- R7: With extended saturation, the clamp is to -2^39 to 2^39-1. Without saturation for that accumulator, results wrap modulo 2^40.
- R8: ovf_a/ovf_b are high exactly while the accumulator value lies outside the 32-bit signed range. sat_sticky_a/sat_sticky_b rise when a write to that accumulator is clamped, and fall only on reset.
- R9: The stored word is bits 31..16 of the selected accumulator after rounding. Conventional rounding adds one when bit 15 is set. Convergent rounding adds one when bits 15..0 exceed 0x8000, or when they equal 0x8000 and bit 16 is set.
- R10: With store saturation set, a rounded value outside the 32-bit signed range stores 0x7FFF (positive) or 0x8000 (negative). Without it, bits 31..16 are stored unchanged.
- R11: store_valid goes high for the cycle after a store. Code 8 always stores. Codes 2, 3 and 4 store when op_wb is high. Every other code never stores, whatever op_wb is. The stored value comes from the selected accumulator as it was before the operation.
- R12: Code 4 (clear) writes zero into the selected accumulator and never sets a sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Load the configuration register |
| cfg_wdata | input | 7 | New configuration bits |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 4 | Operation code |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| op_wb | input | 1 | Request a store on codes that allow one |
| op_x | input | 16 | First multiplier operand |
| op_y | input | 16 | Second multiplier operand |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | A outside the 32-bit range |
| ovf_b | output | 1 | B outside the 32-bit range |
| sat_sticky_a | output | 1 | A write to A was clamped since reset |
| sat_sticky_b | output | 1 | A write to B was clamped since reset |
| store_valid | output | 1 | store_data holds a new word |
| store_data | output | 16 | Rounded, optionally clamped word |

## Verification
The properties assume that rst_n is low from time zero for at least one edge. They also assume that op_code, acc_sel and the operands are known values whenever op_valid is high, since an unknown target would make the accumulator-stability checks meaningless. The bench changes every input only on the falling edge and returns op_valid and cfg_we to zero after each single-cycle request. It never leaves an input undriven. Long runs of full-scale fractional products push the accumulators past both clamp limits, so the saturation properties are exercised with their antecedents true.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_MPY   = 4'd1,
    OP_MAC   = 4'd2,
    OP_MSC   = 4'd3,
    OP_CLR   = 4'd4,
    OP_ADD   = 4'd5,
    OP_SUB   = 4'd6,
    OP_NEG   = 4'd7,
    OP_STORE = 4'd8
  } mac_op_e;

  // Declared MSB first, so frac sits in bit 0 and sat_ext in bit 6.
  typedef struct packed {
    logic sat_ext;
    logic sat_store;
    logic sat_b;
    logic sat_a;
    logic convergent;
    logic unsign;
    logic frac;
  } mac_cfg_t;

  localparam int unsigned CFG_W = $bits(mac_cfg_t);

endpackage

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 40
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          unsign_i,
  input  logic          frac_i,
  output logic [AW-1:0] prod_o
);
  localparam int unsigned PW = 2 * (DW + 1);

  // Extend a 16-bit operand to 17 bits: zero fill when unsigned, sign fill otherwise.
  function automatic logic signed [DW:0] widen(input logic [DW-1:0] v, input logic u);
    return {(u ? 1'b0 : v[DW-1]), v};
  endfunction

  logic signed [DW:0]   xe, ye;
  logic signed [PW-1:0] raw;
  logic signed [PW:0]   aligned;

  assign xe      = widen(x_i, unsign_i);
  assign ye      = widen(y_i, unsign_i);
  assign raw     = PW'(xe) * PW'(ye);
  assign aligned = frac_i ? {raw, 1'b0} : {raw[PW-1], raw};
  assign prod_o  = AW'(aligned);

endmodule

// File: rtl/mac_addsub.sv
module mac_addsub #(
  parameter int unsigned AW = 40,
  parameter int unsigned NW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] addend_i,
  input  logic          sub_i,
  input  logic          sat_en_i,
  input  logic          sat_ext_i,
  output logic [AW-1:0] result_o,
  output logic          clamp_o
);
  localparam int unsigned SW = AW + 1;
  localparam logic [AW-1:0] NMAX = {{(AW-NW+1){1'b0}}, {(NW-1){1'b1}}};
  localparam logic [AW-1:0] NMIN = {{(AW-NW+1){1'b1}}, {(NW-1){1'b0}}};
  localparam logic [AW-1:0] EMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] EMIN = {1'b1, {(AW-1){1'b0}}};

  // True when v is representable as an n-bit signed number.
  function automatic logic fits(input logic signed [SW-1:0] v, input int unsigned n);
    logic signed [SW-1:0] t;
    t = v >>> (n - 1);
    return (&t) || ~(|t);
  endfunction

  logic signed [SW-1:0] a_s, b_s, sum_s;
  logic                 in_lim;

  assign a_s   = SW'($signed(base_i));
  assign b_s   = SW'($signed(addend_i));
  assign sum_s = sub_i ? a_s - b_s : a_s + b_s;

  always_comb begin
    in_lim  = sat_ext_i ? fits(sum_s, AW) : fits(sum_s, NW);
    clamp_o = sat_en_i && !in_lim;
    if (clamp_o)
      result_o = sum_s[SW-1] ? (sat_ext_i ? EMIN : NMIN) : (sat_ext_i ? EMAX : NMAX);
    else
      result_o = sum_s[AW-1:0];
  end

endmodule

// File: rtl/mac_store_round.sv
module mac_store_round #(
  parameter int unsigned AW = 40,
  parameter int unsigned DW = 16,
  parameter int unsigned FW = 16
) (
  input  logic [AW-1:0] acc_i,
  input  logic          convergent_i,
  input  logic          sat_en_i,
  output logic [DW-1:0] word_o
);
  localparam int unsigned SW = AW + 1;
  localparam int unsigned RW = FW + DW;
  localparam logic [FW-1:0] HALF = {1'b1, {(FW-1){1'b0}}};

  function automatic logic fits(input logic signed [SW-1:0] v, input int unsigned n);
    logic signed [SW-1:0] t;
    t = v >>> (n - 1);
    return (&t) || ~(|t);
  endfunction

  logic [FW-1:0]        low;
  logic                 up;
  logic signed [SW-1:0] rnd;
  logic                 clamp;

  assign low = acc_i[FW-1:0];
  assign up  = convergent_i ? ((low > HALF) || ((low == HALF) && acc_i[FW]))
                            : acc_i[FW-1];
  assign rnd = SW'($signed(acc_i)) + (SW'(up) << FW);

  always_comb begin
    clamp = sat_en_i && !fits(rnd, RW);
    if (clamp)
      word_o = rnd[SW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      word_o = rnd[RW-1:FW];
  end

endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine
  import mac_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned GW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               op_valid,
  input  logic [3:0]         op_code,
  input  logic               acc_sel,
  input  logic               op_wb,
  input  logic [DW-1:0]      op_x,
  input  logic [DW-1:0]      op_y,
  output logic [GW+2*DW-1:0] acc_a,
  output logic [GW+2*DW-1:0] acc_b,
  output logic               ovf_a,
  output logic               ovf_b,
  output logic               sat_sticky_a,
  output logic               sat_sticky_b,
  output logic               store_valid,
  output logic [DW-1:0]      store_data
);
  localparam int unsigned AW   = GW + 2 * DW;
  localparam int unsigned NW   = 2 * DW;
  localparam int unsigned NACC = 2;

  mac_cfg_t        cfg_q;
  logic [AW-1:0]   acc_q [NACC];
  logic [NACC-1:0] sticky_q;
  logic [NACC-1:0] ovf_w;
  mac_op_e         op_e;

  // Named internal events, used by the assertions.
  logic          op_fire, acc_write, store_req, clamp_ev, sat_en;
  logic [AW-1:0] cur, oth, prod, base, addend, result;
  logic          sub;
  logic [DW-1:0] word;

  function automatic logic in_norm(input logic [AW-1:0] v);
    logic signed [AW-1:0] t;
    t = $signed(v) >>> (NW - 1);
    return (&t) || ~(|t);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= mac_cfg_t'(cfg_wdata);
  end

  assign op_fire = op_valid;
  assign op_e    = mac_op_e'(op_code);
  assign cur     = acc_q[acc_sel];
  assign oth     = acc_q[~acc_sel];
  assign sat_en  = acc_sel ? cfg_q.sat_b : cfg_q.sat_a;

  mac_multiplier #(.DW(DW), .AW(AW)) u_mul (
    .x_i(op_x), .y_i(op_y), .unsign_i(cfg_q.unsign), .frac_i(cfg_q.frac), .prod_o(prod)
  );

  always_comb begin
    base      = cur;
    addend    = '0;
    sub       = 1'b0;
    acc_write = 1'b0;
    store_req = 1'b0;
    unique case (op_e)
      OP_MPY:   begin base = '0; addend = prod; acc_write = 1'b1; end
      OP_MAC:   begin addend = prod; acc_write = 1'b1; store_req = op_wb; end
      OP_MSC:   begin addend = prod; sub = 1'b1; acc_write = 1'b1; store_req = op_wb; end
      OP_CLR:   begin base = '0; acc_write = 1'b1; store_req = op_wb; end
      OP_ADD:   begin addend = oth; acc_write = 1'b1; end
      OP_SUB:   begin addend = oth; sub = 1'b1; acc_write = 1'b1; end
      OP_NEG:   begin base = '0; addend = cur; sub = 1'b1; acc_write = 1'b1; end
      OP_STORE: store_req = 1'b1;
      default:  ;
    endcase
    acc_write = acc_write && op_fire;
    store_req = store_req && op_fire;
  end

  mac_addsub #(.AW(AW), .NW(NW)) u_add (
    .base_i(base), .addend_i(addend), .sub_i(sub),
    .sat_en_i(sat_en), .sat_ext_i(cfg_q.sat_ext),
    .result_o(result), .clamp_o(clamp_ev)
  );

  mac_store_round #(.AW(AW), .DW(DW), .FW(DW)) u_rnd (
    .acc_i(cur), .convergent_i(cfg_q.convergent), .sat_en_i(cfg_q.sat_store), .word_o(word)
  );

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    logic hit;
    assign hit = acc_write && (acc_sel == 1'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q[i]    <= '0;
        sticky_q[i] <= 1'b0;
      end else if (hit) begin
        acc_q[i] <= result;
        if (clamp_ev) sticky_q[i] <= 1'b1;
      end
    end
    assign ovf_w[i] = !in_norm(acc_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_valid <= 1'b0;
      store_data  <= '0;
    end else begin
      store_valid <= store_req;
      if (store_req) store_data <= word;
    end
  end

  assign acc_a        = acc_q[0];
  assign acc_b        = acc_q[1];
  assign ovf_a        = ovf_w[0];
  assign ovf_b        = ovf_w[1];
  assign sat_sticky_a = sticky_q[0];
  assign sat_sticky_b = sticky_q[1];

  // R4: writing one accumulator leaves the other untouched.
  a_r4_b_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_write && !acc_sel) |=> $stable(acc_b));
  a_r4_a_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_write && acc_sel) |=> $stable(acc_a));
  // R6: a normally saturated write lands inside the 32-bit range.
  a_r6_norm_sat_a: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_write && !acc_sel && cfg_q.sat_a && !cfg_q.sat_ext) |=> !ovf_a);
  a_r6_norm_sat_b: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_write && acc_sel && cfg_q.sat_b && !cfg_q.sat_ext) |=> !ovf_b);
  // R8: sticky flags never fall outside reset.
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sat_sticky_a) && !$fell(sat_sticky_b));
  // R11: multiply-only never produces a store; stores follow an issued op.
  a_r11_mpy_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && op_e == OP_MPY) |=> !store_valid);
  a_r11_store_source: assert property (@(posedge clk) disable iff (!rst_n)
    store_valid |-> $past(op_fire));

endmodule

// File: tb/tb_dsp_mac_engine.sv
module tb_dsp_mac_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic        acc_sel = 1'b0;
  logic        op_wb = 1'b0;
  logic [15:0] op_x = '0, op_y = '0;
  logic [39:0] acc_a, acc_b;
  logic        ovf_a, ovf_b, sat_sticky_a, sat_sticky_b, store_valid;
  logic [15:0] store_data;

  always #10 clk = ~clk;

  dsp_mac_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .op_valid(op_valid), .op_code(op_code), .acc_sel(acc_sel), .op_wb(op_wb),
    .op_x(op_x), .op_y(op_y), .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a),
    .ovf_b(ovf_b), .sat_sticky_a(sat_sticky_a), .sat_sticky_b(sat_sticky_b),
    .store_valid(store_valid), .store_data(store_data)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  longint ma = 0, mb = 0;
  bit     ska = 0, skb = 0, esv = 0;
  int     esd = 0;
  logic [6:0] mcfg = '0;

  function automatic longint sx40(input logic [39:0] v);
    return v[39] ? longint'(v) - (64'sd1 <<< 40) : longint'(v);
  endfunction

  function automatic bit out32(input longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic longint apply(input longint b, input longint d, input bit sat,
                                   input bit ext, inout bit sticky);
    longint r, lim;
    r = b + d;
    if (sat) begin
      lim = ext ? (64'sd1 <<< 39) : (64'sd1 <<< 31);
      if (r > lim - 1)   begin r = lim - 1; sticky = 1; end
      else if (r < -lim) begin r = -lim;    sticky = 1; end
    end else begin
      r = r & ((64'sd1 <<< 40) - 1);
      if (r >= (64'sd1 <<< 39)) r = r - (64'sd1 <<< 40);
    end
    return r;
  endfunction

  function automatic int round_word(input longint v);
    longint low, q;
    bit up;
    low = v & 64'hFFFF;
    if (mcfg[2]) up = (low > 64'h8000) || (low == 64'h8000 && ((v >>> 16) & 1) == 1);
    else         up = (low >= 64'h8000);
    q = (v >>> 16) + (up ? 1 : 0);
    if (mcfg[5]) begin
      if (q > 32767)  q = 32767;
      if (q < -32768) q = -32768;
    end
    return int'(q & 64'hFFFF);
  endfunction

  task automatic model_op(input logic [3:0] c, input bit sel, input bit wb,
                          input logic [15:0] x, input logic [15:0] y);
    longint xa, ya, p, cur, oth, res;
    bit sat, sk, wr;
    xa  = mcfg[1] ? longint'(x) : longint'($signed(x));
    ya  = mcfg[1] ? longint'(y) : longint'($signed(y));
    p   = xa * ya;
    if (mcfg[0]) p = p * 2;
    cur = sel ? mb : ma;
    oth = sel ? ma : mb;
    sat = sel ? mcfg[4] : mcfg[3];
    sk  = sel ? skb : ska;
    wr  = 1;
    res = cur;
    case (c)
      4'd1: res = apply(0, p, sat, mcfg[6], sk);
      4'd2: res = apply(cur, p, sat, mcfg[6], sk);
      4'd3: res = apply(cur, -p, sat, mcfg[6], sk);
      4'd4: res = 0;
      4'd5: res = apply(cur, oth, sat, mcfg[6], sk);
      4'd6: res = apply(cur, -oth, sat, mcfg[6], sk);
      4'd7: res = apply(0, -cur, sat, mcfg[6], sk);
      default: wr = 0;
    endcase
    esv = (c == 4'd8) || (wb && (c == 4'd2 || c == 4'd3 || c == 4'd4));
    if (esv) esd = round_word(cur);
    if (wr) begin
      if (sel) begin mb = res; skb = sk; end
      else     begin ma = res; ska = sk; end
    end
  endtask

  task automatic compare_all(input string tag);
    chk(sx40(acc_a) == ma, tag, sx40(acc_a), ma);
    chk(sx40(acc_b) == mb, tag, sx40(acc_b), mb);
    chk(store_valid == esv, "R11 store_valid", store_valid, esv);
    if (esv) chk(store_data == esd[15:0], tag, store_data, esd);
    chk(ovf_a == out32(ma) && ovf_b == out32(mb), "R8 ovf", {ovf_a, ovf_b},
        {out32(ma), out32(mb)});
    chk(sat_sticky_a == ska && sat_sticky_b == skb, "R8 sticky",
        {sat_sticky_a, sat_sticky_b}, {ska, skb});
  endtask

  // Called on a falling edge; returns on the next falling edge.
  task automatic do_op(input logic [3:0] c, input bit sel, input bit wb,
                       input logic [15:0] x, input logic [15:0] y, input string tag);
    op_valid = 1; op_code = c; acc_sel = sel; op_wb = wb; op_x = x; op_y = y;
    @(posedge clk);
    model_op(c, sel, wb, x, y);
    @(negedge clk);
    op_valid = 0;
    compare_all(tag);
  endtask

  task automatic wcfg(input logic [6:0] v);
    cfg_we = 1; cfg_wdata = v;
    @(posedge clk);
    mcfg = v; esv = 0;
    @(negedge clk);
    cfg_we = 0;
    compare_all("R2");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1 reset");
    chk(store_data == 16'h0, "R1 store_data", store_data, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: signed integer, fractional, unsigned integer products.
    wcfg(7'h00);
    do_op(4'd1, 0, 0, 16'hFFFF, 16'h0002, "R3");
    chk(sx40(acc_a) == -2, "R3 signed int", sx40(acc_a), -2);
    wcfg(7'h01);
    do_op(4'd1, 0, 0, 16'h4000, 16'h4000, "R3");
    chk(sx40(acc_a) == 64'h20000000, "R3 frac", sx40(acc_a), 64'h20000000);
    wcfg(7'h02);
    do_op(4'd1, 1, 0, 16'hFFFF, 16'hFFFF, "R3");
    chk(sx40(acc_b) == 64'hFFFE0001, "R3 unsigned", sx40(acc_b), 64'hFFFE0001);
    // R4: accumulate, subtract, unused codes, idle cycles.
    do_op(4'd2, 1, 0, 16'h0010, 16'h0010, "R4");
    do_op(4'd3, 0, 0, 16'h1234, 16'h0003, "R4");
    for (int c = 9; c < 16; c++) do_op(4'(c), c[0], 1, 16'hFFFF, 16'hFFFF, "R4 unused code");
    op_code = 4'd2; @(negedge clk); compare_all("R4 idle");
    // R5: accumulator-to-accumulator.
    do_op(4'd5, 0, 0, 0, 0, "R5 add");
    do_op(4'd6, 1, 0, 0, 0, "R5 sub");
    do_op(4'd7, 0, 0, 0, 0, "R5 neg");
    // R12: clear with store of old value.
    do_op(4'd4, 0, 1, 0, 0, "R12 clear");
    chk(acc_a == 40'h0, "R12", sx40(acc_a), 0);
    // R9: rounding.
    do_op(4'd1, 0, 0, 16'h0001, 16'h8000, "R9");
    do_op(4'd8, 0, 0, 0, 0, "R9 conventional");
    chk(store_data == 16'h0001, "R9 conv tie", store_data, 1);
    wcfg(7'h06);
    do_op(4'd8, 0, 0, 0, 0, "R9 convergent");
    chk(store_data == 16'h0000, "R9 even tie", store_data, 0);
    do_op(4'd1, 0, 0, 16'h0003, 16'h8000, "R9");
    do_op(4'd8, 0, 0, 0, 0, "R9 convergent");
    chk(store_data == 16'h0002, "R9 odd tie", store_data, 2);
    // R10: store saturation.
    wcfg(7'h02);
    do_op(4'd1, 0, 0, 16'hFFFF, 16'h8000, "R10");
    do_op(4'd8, 0, 0, 0, 0, "R10 no sat");
    chk(store_data == 16'h8000, "R10 wrap", store_data, 16'h8000);
    wcfg(7'h22);
    do_op(4'd8, 0, 0, 0, 0, "R10 sat");
    chk(store_data == 16'h7FFF, "R10 clamp", store_data, 16'h7FFF);
    // R6: normal saturation on A, none on B.
    wcfg(7'h09);
    do_op(4'd1, 0, 0, 16'h8000, 16'h8000, "R6");
    chk(sx40(acc_a) == 64'h7FFFFFFF && sat_sticky_a, "R6 clamp", sx40(acc_a), 64'h7FFFFFFF);
    do_op(4'd1, 1, 0, 16'h8000, 16'h8000, "R6");
    chk(ovf_b && !sat_sticky_b, "R8 ovf no sticky", {ovf_b, sat_sticky_b}, 2);
    // R7: extended saturation on B, wrap on A.
    wcfg(7'h51);
    do_op(4'd4, 1, 0, 0, 0, "R7");
    for (int i = 0; i < 300; i++) do_op(4'd2, 1, 0, 16'h8000, 16'h8000, "R7 ext");
    chk(sx40(acc_b) == 64'h7FFFFFFFFF, "R7 ext clamp", sx40(acc_b), 64'h7FFFFFFFFF);
    wcfg(7'h01);
    do_op(4'd4, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 300; i++) do_op(4'd3, 0, 0, 16'h8000, 16'h8000, "R7 wrap");
    // R11: store gating.
    do_op(4'd1, 0, 1, 16'h0100, 16'h0100, "R11 mpy wb");
    chk(!store_valid, "R11 mpy", store_valid, 0);
    do_op(4'd8, 1, 0, 0, 0, "R11 store");
    chk(store_valid, "R11 store", store_valid, 1);
    do_op(4'd2, 0, 0, 1, 1, "R11 mac no wb");
    // Random mixed operation with a model comparison every cycle.
    for (int i = 0; i < 4000; i++) begin
      if (i % 16 == 0) wcfg(7'($urandom));
      do_op(4'($urandom_range(0, 15)), 1'($urandom), 1'($urandom),
            16'($urandom), 16'($urandom), "R4 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule